// File: doc/BRIEF.md
# ADC Result Averaging and Range Check

This block sits between a successive-approximation converter core and the result storage of a multi-channel ADC. Each cycle it may receive one raw 12-bit code, tagged with the channel it belongs to and with whether that channel is wired differentially. It turns the codes into the final 16-bit result word for that channel.

Channels with averaging enabled have their samples summed in a private per-channel accumulator. A result appears only once the shared sample count has been reached, and the sum can be shifted back down to 12 bits. The result is read as signed or unsigned, with one setting for single-ended and another for differential channels. It is placed right- or left-aligned in the output word.

Each finished result is also tested against a low/high threshold window under a selectable condition. A raw sample at either end of the code range marks the result as saturated. Both events produce a one-cycle pulse and set a per-channel sticky flag when enabled for that channel. Software clears a sticky flag by writing a one to it.

Top module: `adc_result_proc`

## Requirements
- R1: With averaging off for its channel, every accepted sample produces exactly one result. A sample accepted at clock edge N appears on `res_valid`/`res_ch`/`res_data` after edge N+1.
- R2: With averaging on, a channel produces a result only on the sample that brings its count to the target. Earlier samples produce no result and no flag pulse. Each channel keeps its own sum, count and saturation history, so samples of different channels may be interleaved freely.
- R3: For an averaged channel with shifting on, the result value is floor(sum / 2^k). With shifting off, it is the sum itself, kept to the low 16 bits of the word.
- R4: Signedness follows `cfg_diff_signed` for differential samples and `cfg_se_signed` for single-ended ones. A signed result is the value minus 0x800 (shifted case) or minus 0x800·2^k (unshifted case), as 16-bit two's complement. An unsigned result is zero-extended.
- R5: With `cfg_left_align` set, the 16-bit word is the right-aligned word shifted left by 4, with the low 4 bits zero.
- R6: The window test uses the exact result value v. The thresholds are sign-extended when the result is signed and zero-extended otherwise. `cfg_range_cond` encodes 0 = v < low, 1 = low ≤ v < high, 2 = v ≥ high, 3 = v < low or v ≥ high. `range_pulse` rises together with `res_valid` only when the condition holds and `cfg_range_en` bit ch is 1.
- R7: `sat_pulse` rises with `res_valid` when any raw sample folded into that result was 0x000 or 0xFFF and `cfg_sat_en` bit ch is 1.
- R8: `range_flags` and `sat_flags` bit ch set on the same edge as the matching pulse. A bit is cleared on any edge where `flag_clr` bit ch is 1, except when a set of that bit lands on the same edge; in that case the set wins.
- R9: Synchronous reset drives every output to zero and empties every accumulator, discarding partially averaged sums.
- R10: The averaging target is 2^k samples, with k = `cfg_avg_log2`. Any value above the `AVG_LOG2_MAX` parameter is treated as `AVG_LOG2_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Raw sample present this cycle |
| smp_ch | input | CH_W | Channel of the sample |
| smp_code | input | CODE_W | Raw conversion code |
| smp_diff | input | 1 | Sample comes from a differential channel |
| cfg_avg_en | input | NUM_CH | Per-channel averaging enable |
| cfg_avg_log2 | input | LOG_W | Log2 of the averaging count |
| cfg_avg_shift | input | 1 | Shift the sum back to native width |
| cfg_left_align | input | 1 | Left-align the result word |
| cfg_se_signed | input | 1 | Single-ended results are signed |
| cfg_diff_signed | input | 1 | Differential results are signed |
| cfg_thr_lo | input | CODE_W | Low window threshold |
| cfg_thr_hi | input | CODE_W | High window threshold |
| cfg_range_cond | input | 2 | Window condition select |
| cfg_range_en | input | NUM_CH | Per-channel range event enable |
| cfg_sat_en | input | NUM_CH | Per-channel saturation event enable |
| flag_clr | input | NUM_CH | Write-one-to-clear for both sticky flag sets |
| res_valid | output | 1 | Result word valid |
| res_ch | output | CH_W | Channel of the result |
| res_data | output | OUT_W | Result word |
| range_pulse | output | 1 | Window event for this result |
| sat_pulse | output | 1 | Saturation event for this result |
| range_flags | output | NUM_CH | Sticky window event flags |
| sat_flags | output | NUM_CH | Sticky saturation flags |

## Verification
The bench builds the block with NUM_CH = 4 and AVG_LOG2_MAX = 4. With these values every one of the 4096 codes can be pushed through each combination of single-ended signedness, differential signedness and alignment, while the window condition, channel and wiring type rotate with the code. Because unshifted sums stay within 16 bits, averaged results compare exactly. The 3-bit count field can also hold 5 to 7, which brings the clamp of R10 within reach. Interleaved random traffic across two averaging channels, together with a reset in the middle of an average, exercises the per-channel accumulators and the discard on reset.

// File: rtl/adc_rp_pkg.sv
package adc_rp_pkg;

  // Window condition encoding; the order is fixed by the cfg_range_cond field.
  typedef enum logic [1:0] {
    RC_BELOW   = 2'd0,
    RC_INSIDE  = 2'd1,
    RC_ABOVE   = 2'd2,
    RC_OUTSIDE = 2'd3
  } range_cond_e;

endpackage

// File: rtl/adc_rp_accum.sv
module adc_rp_accum #(
  parameter int NUM_CH       = 16,
  parameter int CODE_W       = 12,
  parameter int AVG_LOG2_MAX = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LOG_W = $clog2(AVG_LOG2_MAX + 1),
  localparam int ACC_W = CODE_W + AVG_LOG2_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_diff,
  input  logic [NUM_CH-1:0] avg_en,
  input  logic [LOG_W-1:0]  avg_log2,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_ch,
  output logic [ACC_W-1:0]  out_sum,
  output logic              out_diff,
  output logic              out_sat,
  output logic [LOG_W-1:0]  out_k
);

  localparam int CNT_W = AVG_LOG2_MAX + 1;

  logic [ACC_W-1:0]  acc_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [NUM_CH-1:0] sat_q;

  logic              chan_avg;
  logic [LOG_W-1:0]  k_eff;
  logic              raw_sat;
  logic [ACC_W-1:0]  sum_nx;
  logic [CNT_W-1:0]  cnt_nx;
  logic [CNT_W-1:0]  cnt_goal;
  logic              sat_nx;
  logic              done;

  always_comb begin
    chan_avg = avg_en[in_ch];
    if (!chan_avg)
      k_eff = '0;
    else if (avg_log2 > LOG_W'(AVG_LOG2_MAX))
      k_eff = LOG_W'(AVG_LOG2_MAX);
    else
      k_eff = avg_log2;
    raw_sat  = (in_code == '0) || (in_code == {CODE_W{1'b1}});
    sum_nx   = (chan_avg ? acc_q[in_ch] : '0) + ACC_W'(in_code);
    cnt_nx   = (chan_avg ? cnt_q[in_ch] : '0) + CNT_W'(1);
    sat_nx   = (chan_avg & sat_q[in_ch]) | raw_sat;
    cnt_goal = CNT_W'(1) << k_eff;
    done     = (cnt_nx >= cnt_goal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        acc_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      sat_q     <= '0;
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_sum   <= '0;
      out_diff  <= 1'b0;
      out_sat   <= 1'b0;
      out_k     <= '0;
    end else begin
      out_valid <= in_valid && done;
      if (in_valid) begin
        if (done) begin
          acc_q[in_ch] <= '0;
          cnt_q[in_ch] <= '0;
          sat_q[in_ch] <= 1'b0;
        end else begin
          acc_q[in_ch] <= sum_nx;
          cnt_q[in_ch] <= cnt_nx;
          sat_q[in_ch] <= sat_nx;
        end
        out_ch   <= in_ch;
        out_sum  <= sum_nx;
        out_diff <= in_diff;
        out_sat  <= sat_nx;
        out_k    <= k_eff;
      end
    end
  end

  // R1: a finished sum only leaves this stage right after an accepted sample
  a_r1_valid_needs_sample: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R2: a finished sum never exceeds full scale times the sample count
  a_r2_sum_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum <= (ACC_W'({CODE_W{1'b1}}) << out_k)));

  // R7: a single-sample result is saturated exactly when its code is at a rail
  a_r7_single_sat: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_k == '0) |->
      (out_sat == (($past(in_code) == '0) || ($past(in_code) == {CODE_W{1'b1}}))));

endmodule

// File: rtl/adc_rp_format.sv
module adc_rp_format #(
  parameter int CODE_W       = 12,
  parameter int OUT_W        = 16,
  parameter int AVG_LOG2_MAX = 8,
  localparam int LOG_W = $clog2(AVG_LOG2_MAX + 1),
  localparam int ACC_W = CODE_W + AVG_LOG2_MAX,
  localparam int WIDE  = ((ACC_W > OUT_W) ? ACC_W : OUT_W) + 1
) (
  input  logic [ACC_W-1:0]       sum,
  input  logic [LOG_W-1:0]       k,
  input  logic                   do_shift,
  input  logic                   is_signed,
  input  logic                   left_align,
  output logic signed [WIDE-1:0] value,
  output logic [OUT_W-1:0]       word
);

  localparam int ALIGN = OUT_W - CODE_W;

  logic [ACC_W-1:0]       scaled;
  logic signed [WIDE-1:0] base;
  logic signed [WIDE-1:0] mid;
  logic signed [WIDE-1:0] offset;

  always_comb begin
    mid = '0;
    mid[CODE_W-1] = 1'b1;
    scaled = do_shift ? (sum >> k) : sum;
    base   = $signed({{(WIDE - ACC_W){1'b0}}, scaled});
    offset = do_shift ? mid : (mid <<< k);
    value  = is_signed ? (base - offset) : base;
    word   = left_align ? (value[OUT_W-1:0] << ALIGN) : value[OUT_W-1:0];
  end

endmodule

// File: rtl/adc_rp_window.sv
module adc_rp_window
  import adc_rp_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int WIDE   = 21
) (
  input  logic signed [WIDE-1:0] value,
  input  logic [CODE_W-1:0]      thr_lo,
  input  logic [CODE_W-1:0]      thr_hi,
  input  logic                   is_signed,
  input  logic [1:0]             cond,
  output logic                   hit
);

  logic signed [WIDE-1:0] lo_x;
  logic signed [WIDE-1:0] hi_x;
  logic                   below;
  logic                   above;

  always_comb begin
    lo_x  = $signed({{(WIDE - CODE_W){is_signed & thr_lo[CODE_W-1]}}, thr_lo});
    hi_x  = $signed({{(WIDE - CODE_W){is_signed & thr_hi[CODE_W-1]}}, thr_hi});
    below = value < lo_x;
    above = value >= hi_x;
    case (range_cond_e'(cond))
      RC_BELOW:  hit = below;
      RC_INSIDE: hit = !below && !above;
      RC_ABOVE:  hit = above;
      default:   hit = below || above;
    endcase
  end

endmodule

// File: rtl/adc_result_proc.sv
module adc_result_proc #(
  parameter int NUM_CH       = 16,
  parameter int CODE_W       = 12,
  parameter int OUT_W        = 16,
  parameter int AVG_LOG2_MAX = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LOG_W = $clog2(AVG_LOG2_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_ch,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              smp_diff,
  input  logic [NUM_CH-1:0] cfg_avg_en,
  input  logic [LOG_W-1:0]  cfg_avg_log2,
  input  logic              cfg_avg_shift,
  input  logic              cfg_left_align,
  input  logic              cfg_se_signed,
  input  logic              cfg_diff_signed,
  input  logic [CODE_W-1:0] cfg_thr_lo,
  input  logic [CODE_W-1:0] cfg_thr_hi,
  input  logic [1:0]        cfg_range_cond,
  input  logic [NUM_CH-1:0] cfg_range_en,
  input  logic [NUM_CH-1:0] cfg_sat_en,
  input  logic [NUM_CH-1:0] flag_clr,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic [OUT_W-1:0]  res_data,
  output logic              range_pulse,
  output logic              sat_pulse,
  output logic [NUM_CH-1:0] range_flags,
  output logic [NUM_CH-1:0] sat_flags
);

  localparam int ACC_W = CODE_W + AVG_LOG2_MAX;
  localparam int WIDE  = ((ACC_W > OUT_W) ? ACC_W : OUT_W) + 1;

  logic              a_valid;
  logic [CH_W-1:0]   a_ch;
  logic [ACC_W-1:0]  a_sum;
  logic              a_diff;
  logic              a_sat;
  logic [LOG_W-1:0]  a_k;

  logic                   use_signed;
  logic signed [WIDE-1:0] f_value;
  logic [OUT_W-1:0]       f_word;
  logic                   w_hit;
  logic                   rng_set;
  logic                   sat_set;
  logic [NUM_CH-1:0]      rng_vec;
  logic [NUM_CH-1:0]      sat_vec;

  adc_rp_accum #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .AVG_LOG2_MAX(AVG_LOG2_MAX)
  ) u_accum (
    .clk(clk), .rst(rst),
    .in_valid(smp_valid), .in_ch(smp_ch), .in_code(smp_code), .in_diff(smp_diff),
    .avg_en(cfg_avg_en), .avg_log2(cfg_avg_log2),
    .out_valid(a_valid), .out_ch(a_ch), .out_sum(a_sum),
    .out_diff(a_diff), .out_sat(a_sat), .out_k(a_k)
  );

  assign use_signed = a_diff ? cfg_diff_signed : cfg_se_signed;

  adc_rp_format #(
    .CODE_W(CODE_W), .OUT_W(OUT_W), .AVG_LOG2_MAX(AVG_LOG2_MAX)
  ) u_format (
    .sum(a_sum), .k(a_k), .do_shift(cfg_avg_shift), .is_signed(use_signed),
    .left_align(cfg_left_align), .value(f_value), .word(f_word)
  );

  adc_rp_window #(
    .CODE_W(CODE_W), .WIDE(WIDE)
  ) u_window (
    .value(f_value), .thr_lo(cfg_thr_lo), .thr_hi(cfg_thr_hi),
    .is_signed(use_signed), .cond(cfg_range_cond), .hit(w_hit)
  );

  always_comb begin
    rng_set = a_valid && w_hit && cfg_range_en[a_ch];
    sat_set = a_valid && a_sat && cfg_sat_en[a_ch];
    rng_vec = rng_set ? (NUM_CH'(1) << a_ch) : '0;
    sat_vec = sat_set ? (NUM_CH'(1) << a_ch) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_ch      <= '0;
      res_data    <= '0;
      range_pulse <= 1'b0;
      sat_pulse   <= 1'b0;
      range_flags <= '0;
      sat_flags   <= '0;
    end else begin
      res_valid   <= a_valid;
      range_pulse <= rng_set;
      sat_pulse   <= sat_set;
      if (a_valid) begin
        res_ch   <= a_ch;
        res_data <= f_word;
      end
      range_flags <= (range_flags & ~flag_clr) | rng_vec;
      sat_flags   <= (sat_flags & ~flag_clr) | sat_vec;
    end
  end

  // R6: a window event is always tied to a delivered result
  a_r6_pulse_with_result: assert property (@(posedge clk) disable iff (rst)
    range_pulse |-> res_valid);

  // R7: a saturation event is always tied to a delivered result
  a_r7_pulse_with_result: assert property (@(posedge clk) disable iff (rst)
    sat_pulse |-> res_valid);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag_chk
      // R8: a sticky bit only rises with an event on its own channel
      a_r8_range_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(range_flags[c]) |-> (range_pulse && res_ch == CH_W'(c)));
      a_r8_sat_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flags[c]) |-> (sat_pulse && res_ch == CH_W'(c)));
      // R8: a sticky bit only falls after a clear request for it
      a_r8_range_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(range_flags[c]) |-> $past(flag_clr[c]));
      a_r8_sat_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(sat_flags[c]) |-> $past(flag_clr[c]));
    end
  endgenerate

endmodule

// File: tb/adc_result_proc_test.sv
module adc_result_proc_test;

  localparam int NCH  = 4;
  localparam int CW   = 12;
  localparam int OW   = 16;
  localparam int AMAX = 4;
  localparam int CHW  = 2;
  localparam int LW   = 3;

  logic           clk = 1'b0;
  logic           rst;
  logic           smp_valid;
  logic [CHW-1:0] smp_ch;
  logic [CW-1:0]  smp_code;
  logic           smp_diff;
  logic [NCH-1:0] cfg_avg_en;
  logic [LW-1:0]  cfg_avg_log2;
  logic           cfg_avg_shift;
  logic           cfg_left_align;
  logic           cfg_se_signed;
  logic           cfg_diff_signed;
  logic [CW-1:0]  cfg_thr_lo;
  logic [CW-1:0]  cfg_thr_hi;
  logic [1:0]     cfg_range_cond;
  logic [NCH-1:0] cfg_range_en;
  logic [NCH-1:0] cfg_sat_en;
  logic [NCH-1:0] flag_clr;
  logic           res_valid;
  logic [CHW-1:0] res_ch;
  logic [OW-1:0]  res_data;
  logic           range_pulse;
  logic           sat_pulse;
  logic [NCH-1:0] range_flags;
  logic [NCH-1:0] sat_flags;

  always #2 clk = ~clk;

  adc_result_proc #(.NUM_CH(NCH), .CODE_W(CW), .OUT_W(OW), .AVG_LOG2_MAX(AMAX)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_code(smp_code),
    .smp_diff(smp_diff), .cfg_avg_en(cfg_avg_en), .cfg_avg_log2(cfg_avg_log2),
    .cfg_avg_shift(cfg_avg_shift), .cfg_left_align(cfg_left_align),
    .cfg_se_signed(cfg_se_signed), .cfg_diff_signed(cfg_diff_signed),
    .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi), .cfg_range_cond(cfg_range_cond),
    .cfg_range_en(cfg_range_en), .cfg_sat_en(cfg_sat_en), .flag_clr(flag_clr),
    .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .range_pulse(range_pulse), .sat_pulse(sat_pulse),
    .range_flags(range_flags), .sat_flags(sat_flags)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_sum [NCH];
  int m_cnt [NCH];
  bit m_sat [NCH];
  logic [NCH-1:0] m_rflg;
  logic [NCH-1:0] m_sflg;
  logic [15:0]    lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic model_clear();
    for (int i = 0; i < NCH; i++) begin
      m_sum[i] = 0;
      m_cnt[i] = 0;
      m_sat[i] = 1'b0;
    end
    m_rflg = '0;
    m_sflg = '0;
  endtask

  // Call at a falling edge; returns at the falling edge where the result is visible.
  task automatic do_one(input int ch, input int code, input bit diff, input logic [NCH-1:0] clr);
    int k, v, lo_i, hi_i, data;
    bit s, done, below, above, hit, exp_r, exp_s;
    string dtag;
    k = cfg_avg_en[ch] ? ((int'(cfg_avg_log2) > AMAX) ? AMAX : int'(cfg_avg_log2)) : 0;
    if (!cfg_avg_en[ch]) begin
      m_sum[ch] = 0; m_cnt[ch] = 0; m_sat[ch] = 1'b0;
    end
    m_sum[ch] += code;
    m_cnt[ch] += 1;
    m_sat[ch] |= (code == 0) || (code == 4095);
    done = m_cnt[ch] >= (1 << k);
    s = diff ? cfg_diff_signed : cfg_se_signed;
    v = 0; data = 0; exp_r = 0; exp_s = 0;
    if (done) begin
      if (cfg_avg_shift) v = (m_sum[ch] >> k) - (s ? 2048 : 0);
      else               v = m_sum[ch] - (s ? (2048 << k) : 0);
      data = v & 16'hFFFF;
      if (cfg_left_align) data = (data << 4) & 16'hFFFF;
      lo_i = int'(cfg_thr_lo); hi_i = int'(cfg_thr_hi);
      if (s && lo_i >= 2048) lo_i -= 4096;
      if (s && hi_i >= 2048) hi_i -= 4096;
      below = v < lo_i;
      above = v >= hi_i;
      case (cfg_range_cond)
        2'd0: hit = below;
        2'd1: hit = !below && !above;
        2'd2: hit = above;
        default: hit = below || above;
      endcase
      exp_r = hit && cfg_range_en[ch];
      exp_s = m_sat[ch] && cfg_sat_en[ch];
      m_sum[ch] = 0; m_cnt[ch] = 0; m_sat[ch] = 1'b0;
    end
    m_rflg = (m_rflg & ~clr) | (NCH'(exp_r) << ch);
    m_sflg = (m_sflg & ~clr) | (NCH'(exp_s) << ch);

    smp_valid = 1'b1; smp_ch = CHW'(ch); smp_code = CW'(code); smp_diff = diff;
    @(negedge clk);
    smp_valid = 1'b0; flag_clr = clr;
    @(negedge clk);
    flag_clr = '0;

    if (cfg_left_align)     dtag = "R5 left-aligned word";
    else if (k > 0)         dtag = "R3 averaged value";
    else                    dtag = "R4 signedness";
    if (done) begin
      check(res_valid === 1'b1, "R1 result valid", int'(res_valid), 1);
      check(res_ch === CHW'(ch), "R1 result channel", int'(res_ch), ch);
      check(res_data === OW'(data), dtag, int'(res_data), data);
      check(range_pulse === exp_r, "R6 range pulse", int'(range_pulse), int'(exp_r));
      check(sat_pulse === exp_s, "R7 saturation pulse", int'(sat_pulse), int'(exp_s));
    end else begin
      check(res_valid === 1'b0, "R2 no result before count", int'(res_valid), 0);
      check(range_pulse === 1'b0 && sat_pulse === 1'b0, "R2 no pulse before count",
            int'({range_pulse, sat_pulse}), 0);
    end
    check(range_flags === m_rflg, "R8 range flags", int'(range_flags), int'(m_rflg));
    check(sat_flags === m_sflg, "R8 saturation flags", int'(sat_flags), int'(m_sflg));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    check(res_valid === 1'b0 && range_pulse === 1'b0 && sat_pulse === 1'b0,
          "R9 reset pulses", int'({res_valid, range_pulse, sat_pulse}), 0);
    check(res_data === '0 && res_ch === '0, "R9 reset data", int'(res_data), 0);
    check(range_flags === '0 && sat_flags === '0, "R9 reset flags",
          int'({range_flags, sat_flags}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; smp_valid = 1'b0; smp_ch = '0; smp_code = '0; smp_diff = 1'b0;
    cfg_avg_en = '0; cfg_avg_log2 = '0; cfg_avg_shift = 1'b0; cfg_left_align = 1'b0;
    cfg_se_signed = 1'b0; cfg_diff_signed = 1'b0; cfg_thr_lo = 12'h300; cfg_thr_hi = 12'h5FF;
    cfg_range_cond = 2'd3; cfg_range_en = 4'b1011; cfg_sat_en = 4'b0111; flag_clr = '0;
    @(negedge clk);
    do_reset();

    // Exhaustive code sweep, single samples (R1, R4, R5, R6, R7, R8)
    for (int sel = 0; sel < 8; sel++) begin
      cfg_se_signed   = sel[0];
      cfg_diff_signed = sel[1];
      cfg_left_align  = sel[2];
      for (int code = 0; code < 4096; code++) begin
        cfg_range_cond = code[1:0];
        do_one((code >> 2) % 4, code, code[4], (code % 64 == 5) ? 4'b1111 : 4'b0000);
      end
    end

    // Averaging with interleaved channels (R2, R3, R4, R10)
    cfg_avg_en = 4'b0110;
    cfg_range_cond = 2'd3;
    cfg_range_en = 4'b1111;
    cfg_sat_en = 4'b1111;
    for (int lg = 0; lg < 8; lg++) begin
      for (int sh = 0; sh < 2; sh++) begin
        for (int sg = 0; sg < 2; sg++) begin
          cfg_avg_log2    = LW'(lg);
          cfg_avg_shift   = sh[0];
          cfg_se_signed   = sg[0];
          cfg_diff_signed = !sg[0];
          cfg_left_align  = (lg == 2) && (sh == 1);
          for (int n = 0; n < 40; n++) begin
            int code;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            code = int'(lfsr[11:0]);
            if (n % 7 == 3) code = 4095;
            if (n % 11 == 6) code = 0;
            do_one(int'(lfsr[13:12]), code, lfsr[14], (n % 13 == 12) ? 4'b1010 : 4'b0000);
          end
        end
      end
    end

    // Reset in the middle of an average discards it (R9)
    cfg_avg_en = 4'b0001; cfg_avg_log2 = 3'd2; cfg_avg_shift = 1'b1;
    cfg_se_signed = 1'b0; cfg_left_align = 1'b0;
    do_one(0, 4095, 1'b0, '0);
    do_one(0, 4095, 1'b0, '0);
    do_reset();
    do_one(0, 100, 1'b0, '0);
    do_one(0, 200, 1'b0, '0);
    do_one(0, 300, 1'b0, '0);
    do_one(0, 401, 1'b0, '0);

    summary();
    $finish;
  end

endmodule